// File: doc/BRIEF.md
# Predicated Narrowing Vector Store Unit

This block turns one vector register of 64-bit elements into a single contiguous memory write of 16-bit values. Each element is cut down to its low halfword, and the halfwords are packed side by side. The write address is a base register plus an index that counts halfwords. A per-element predicate decides which halfwords reach memory. Masked elements produce no byte strobes, so the memory under them keeps its old contents.

An external address-check stage gives one fault bit per element. A fault counts only when it belongs to an active element. If any active element faults, the unit reports the lowest such element and drops the whole write. A masked element never raises a fault, even when its address is flagged.

The store is taken on the cycle `start_i` is high. Every result is registered and appears one cycle later, together with a one-cycle `done_o` pulse. The results then hold until the next store is accepted.

Top module: `narrow_store_unit`

## Requirements
- R1: Bits [16*i+15:16*i] of `wr_data_o` equal bits [64*i+15:64*i] of `vec_i`. The upper 48 bits of each element are dropped without saturation. This holds whether or not the element is active and whether or not a fault is reported.
- R2: `wr_addr_o` equals `base_i + 2*index_i`, computed modulo 2^64. Overflow is not detected.
- R3: Element i is active exactly when `pred_i[8*i]` is 1. All other predicate bits have no effect on any output.
- R4: When no fault is reported, strobe bits 2*i and 2*i+1 of `wr_be_o` are both 1 if element i is active and both 0 if it is not.
- R5: A fault input on an inactive element is ignored. It cannot set `fault_o` and cannot remove strobes from active elements.
- R6: If one or more active elements have their fault input set, `fault_o` is 1 and `fault_elem_o` holds the lowest-numbered active faulting element. In that case every bit of `wr_be_o` is 0. When no fault is reported, `fault_elem_o` is 0.
- R7: A store whose governing predicate bits are all 0 completes with `done_o`, with every strobe at 0 and with `fault_o` at 0.
- R8: The outputs of a store accepted on cycle N are valid on cycle N+1, and `done_o` is high on that cycle only. A new store can be accepted on every cycle. On a cycle with no start, `done_o` is 0 the next cycle and the other outputs keep their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept a store this cycle |
| base_i | input | 64 | Base address register |
| index_i | input | 64 | Index register, in halfwords |
| vec_i | input | VLEN | Source vector, 64-bit elements |
| pred_i | input | VLEN/8 | Governing predicate, one bit per vector byte |
| elem_fault_i | input | VLEN/64 | Per-element fault from the address-check stage |
| wr_addr_o | output | 64 | Effective write address |
| wr_data_o | output | VLEN/4 | Packed halfword write data |
| wr_be_o | output | VLEN/32 | Byte-enable strobes |
| fault_o | output | 1 | Store faulted; write suppressed |
| fault_elem_o | output | $clog2(VLEN/64) | Lowest active faulting element |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Strobe generation and fault reporting both depend on the same predicate and fault inputs in the same store, so they interact. The bench sets fault bits on masked elements and on active elements together. It also places a masked faulting element below an active faulting one, so that a wrong priority or a missing predicate gate shows up as a wrong element number or as strobes that were wrongly cleared or wrongly kept. A behavioural model recomputes the address, packed data, strobes and fault outcome from the inputs on every clock. The bench compares every output against it, including during back-to-back starts and during idle cycles where the outputs must hold.

// File: rtl/narrow_store_unit.sv
module narrow_store_unit #(
  parameter int VLEN = 256,
  parameter int AW   = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [AW-1:0]                base_i,
  input  logic [AW-1:0]                index_i,
  input  logic [VLEN-1:0]              vec_i,
  input  logic [VLEN/8-1:0]            pred_i,
  input  logic [VLEN/64-1:0]           elem_fault_i,
  output logic [AW-1:0]                wr_addr_o,
  output logic [VLEN/4-1:0]            wr_data_o,
  output logic [VLEN/32-1:0]           wr_be_o,
  output logic                         fault_o,
  output logic [$clog2(VLEN/64)-1:0]   fault_elem_o,
  output logic                         done_o
);
  localparam int NE = VLEN / 64;
  localparam int DW = VLEN / 4;
  localparam int BW = VLEN / 32;
  localparam int EW = $clog2(NE);

  logic [NE-1:0] act, hit;
  logic [DW-1:0] packed_d;
  logic [BW-1:0] be_d;
  logic [EW-1:0] first_hit;
  logic [AW-1:0] eff_addr;

  for (genvar g = 0; g < NE; g++) begin : g_elem
    assign act[g] = pred_i[8*g];
    assign hit[g] = act[g] & elem_fault_i[g];
    assign packed_d[16*g +: 16] = vec_i[64*g +: 16];
    assign be_d[2*g +: 2] = {2{act[g]}};
  end

  always_comb begin
    first_hit = '0;
    for (int i = NE - 1; i >= 0; i--)
      if (hit[i]) first_hit = EW'(i);
  end

  assign eff_addr = base_i + {index_i[AW-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      wr_be_o      <= '0;
      fault_o      <= 1'b0;
      fault_elem_o <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        wr_addr_o    <= eff_addr;
        wr_data_o    <= packed_d;
        wr_be_o      <= (|hit) ? '0 : be_d;
        fault_o      <= |hit;
        fault_elem_o <= first_hit;
      end
    end
  end

  p_done_follows_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o && $stable(wr_addr_o) && $stable(wr_be_o) && $stable(fault_o));

  p_fault_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> wr_be_o == '0);

  p_masked_no_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && ((pred_i[0] & elem_fault_i[0]) == 1'b0) && ((act & elem_fault_i) == '0) |=> !fault_o);

  p_empty_pred_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && act == '0 |=> wr_be_o == '0 && !fault_o);

  for (genvar g = 0; g < NE; g++) begin : g_chk
    p_masked_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !pred_i[8*g] |=> !wr_be_o[2*g] && !wr_be_o[2*g+1]);
  end
endmodule

// File: tb/narrow_store_unit_tb_top.sv
module narrow_store_unit_tb_top;
  localparam int VLEN = 256;
  localparam int NE = VLEN / 64;
  localparam int DW = VLEN / 4;
  localparam int BW = VLEN / 32;
  localparam int PW = VLEN / 8;
  localparam int EW = $clog2(NE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] base = '0, index = '0;
  logic [VLEN-1:0] vec = '0;
  logic [PW-1:0] pred = '0;
  logic [NE-1:0] flt = '0;
  logic [63:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [BW-1:0] wr_be;
  logic fault;
  logic [EW-1:0] fault_elem;
  logic done;

  logic [63:0] e_addr;
  logic [DW-1:0] e_data;
  logic [BW-1:0] e_be;
  logic e_fault, e_done;
  integer e_elem;
  int tests = 0, fails = 0;
  bit finished = 0;
  string scen = "reset";

  always #5 clk = ~clk;

  narrow_store_unit #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .index_i(index),
    .vec_i(vec), .pred_i(pred), .elem_fault_i(flt), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_be_o(wr_be), .fault_o(fault),
    .fault_elem_o(fault_elem), .done_o(done));

  task automatic model();
    bit found;
    if (!rst_n) begin
      e_addr = '0; e_data = '0; e_be = '0; e_fault = 0; e_elem = 0; e_done = 0;
    end else begin
      e_done = start;
      if (start) begin
        e_addr = base + index * 64'd2;
        found = 0; e_elem = 0;
        for (int i = 0; i < NE; i++) begin
          e_data[16*i +: 16] = vec[64*i +: 16];
          e_be[2*i] = pred[8*i];
          e_be[2*i+1] = pred[8*i];
          if (pred[8*i] && flt[i] && !found) begin found = 1; e_elem = i; end
        end
        e_fault = found;
        if (found) e_be = '0;
      end
    end
  endtask

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("R2 addr", 512'(wr_addr), 512'(e_addr));
    chk("R1 data", 512'(wr_data), 512'(e_data));
    chk("R4 strobes", 512'(wr_be), 512'(e_be));
    chk("R6 fault", 512'(fault), 512'(e_fault));
    chk("R6 elem", 512'(fault_elem), 512'(e_elem));
    chk("R8 done", 512'(done), 512'(e_done));
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PW-1:0] rnd_pred();
    logic [PW-1:0] p;
    for (int i = 0; i < PW / 32; i++) p[32*i +: 32] = $urandom;
    return p;
  endfunction

  task automatic issue(string s, logic [63:0] b, logic [63:0] ix,
                       logic [PW-1:0] p, logic [NE-1:0] f);
    scen = s; start = 1; base = b; index = ix; vec = rnd_vec(); pred = p; flt = f;
    tick();
    start = 0; pred = rnd_pred(); flt = NE'($urandom);
  endtask

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    issue("R1 R4 all active", 64'h1000, 64'h4, {PW{1'b1}}, '0);
    issue("R3 only governing bits", 64'h2000, 64'h3, PW'(32'h0101_0001), '0);
    issue("R3 noise bits ignored", 64'h2000, 64'h3, PW'(32'hFEFE_FEFE), '0);
    issue("R5 fault on masked only", 64'h3000, 64'h0, PW'(32'h0001_0001), NE'(4'b1010));
    issue("R6 lowest active fault", 64'h4000, 64'h1, PW'(32'h0101_0100), NE'(4'b1111));
    issue("R5 R6 masked fault below", 64'h5000, 64'h9, PW'(32'h0100_0100), NE'(4'b1101));
    issue("R7 empty predicate", 64'h6000, 64'h2, PW'(32'hFEFE_FEFE), {NE{1'b1}});
    issue("R2 wrap", 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0002, {PW{1'b1}}, '0);
    scen = "R8 idle hold";
    repeat (3) tick();
    scen = "R8 back to back";
    start = 1;
    for (int k = 0; k < 6; k++) begin
      base = {$urandom, $urandom}; index = {$urandom, $urandom};
      vec = rnd_vec(); pred = rnd_pred(); flt = NE'($urandom);
      tick();
    end
    start = 0;
    scen = "random mix";
    for (int k = 0; k < 300; k++) begin
      start = ($urandom % 3) != 0;
      base = {$urandom, $urandom}; index = {$urandom, $urandom};
      vec = rnd_vec(); pred = rnd_pred(); flt = NE'($urandom);
      tick();
    end
    start = 0;
    tick();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", scen);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule